// File: doc/BRIEF.md
# I2C Parallel Port Expander Target

This block is an I2C target that connects one 8-bit parallel port to the serial bus. It has no internal registers. Each data byte of a write transfer goes straight to the output latch. Each byte of a read transfer is a fresh sample of the port pins. The bus lines are oversampled on a fast system clock through a two-flop synchronizer. SDA is pulled low through an open-drain enable, and the enable is active high.

The 7-bit target address has a fixed upper part, 4'b0100 by default. The lower three bits come from the address-select pins. Other blocks next to this one (the interrupt logic and the pull-up pulse generator) act on the one-cycle write and read strobes. Clock stretching and pad behaviour are outside this block.

Top module: `pexp_i2c_target`

## Requirements
- R1: After reset, `port_out` is 8'hFF, `sda_oe` is 0, and neither strobe is active.
- R2: The target acknowledges an address byte whose upper seven bits equal {4'b0100, addr_sel[2], addr_sel[1], addr_sel[0]}. The address byte is received MSB first, and its bit 0 is the direction (1 = read). The acknowledge is SDA held low through the ninth SCL high period.
- R3: The target does not acknowledge a non-matching address or the all-zero general call address. The bytes that follow in that transfer leave `port_out` unchanged and get no acknowledge.
- R4: In a write transfer the target acknowledges each data byte. `port_out` still holds its old value during that acknowledge clock. It takes the new byte only after the acknowledge clock falls, and `wr_stb` pulses for one cycle at that point.
- R5: Several data bytes in one write transfer each update `port_out` in turn.
- R6: A stop in the middle of a data byte discards the partial byte, and `port_out` keeps the last acknowledged value.
- R7: In a read transfer, `port_in` is captured at the SCL fall that begins each byte and is sent MSB first. `rd_stb` pulses for one cycle at each capture. A read does not change `port_out`.
- R8: A read goes on for as long as the controller acknowledges. Each new byte is a fresh sample of `port_in`.
- R9: When the controller does not acknowledge a read byte, the target releases SDA and goes idle. Clocks after that, with no start, get no acknowledge. The next start is served normally.
- R10: A repeated start in the middle of a byte drops the partial byte and begins a new address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |
| addr_sel | input | 3 | Low bits of the target address |
| port_in | input | 8 | Port pin levels, sampled for reads |
| port_out | output | 8 | Output latch driving the port |
| wr_stb | output | 1 | One-cycle pulse when `port_out` takes a new byte |
| rd_stb | output | 1 | One-cycle pulse when `port_in` is captured |

## Verification
The bench checks that `port_out` still holds its old value during the write acknowledge. A design that copied the byte one edge early would change `port_out` before the acknowledge finished. It cuts a byte short with a stop and with a repeated start. A design that let partial bytes through would put a garbage value on the port. It changes `port_in` partway through a read to show that each byte is captured at its opening SCL fall and not at its close. A wrong capture point would return the wrong byte. It also clocks the bus after a controller NACK. A target that stayed active would acknowledge bytes it should ignore.

// File: rtl/pexp_pkg.sv
package pexp_pkg;

   localparam int BYTE_W = 8;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_AACK,
      ST_WDAT,
      ST_WACK,
      ST_RDAT,
      ST_RACK
   } pexp_state_e;

   typedef struct packed {
      logic start;
      logic stop;
      logic rise;
      logic fall;
   } bus_evt_t;

endpackage

// File: rtl/pexp_line_sync.sv
module pexp_line_sync #(
   parameter int STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scl_i,
   input  logic               sda_i,
   output logic               scl_s,
   output logic               sda_s,
   output pexp_pkg::bus_evt_t evt
);

   if (STAGES < 2) begin : g_bad_stages
      $error("pexp_line_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] scl_pipe;
   logic [STAGES-1:0] sda_pipe;
   logic              scl_q;
   logic              sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_pipe <= '1;
         sda_pipe <= '1;
         scl_q    <= 1'b1;
         sda_q    <= 1'b1;
      end else begin
         scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
         sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
         scl_q    <= scl_pipe[STAGES-1];
         sda_q    <= sda_pipe[STAGES-1];
      end
   end

   assign scl_s = scl_pipe[STAGES-1];
   assign sda_s = sda_pipe[STAGES-1];

   always_comb begin
      evt.rise  = scl_s & ~scl_q;
      evt.fall  = ~scl_s & scl_q;
      evt.start = scl_s & scl_q & sda_q & ~sda_s;
      evt.stop  = scl_s & scl_q & ~sda_q & sda_s;
   end

endmodule

// File: rtl/pexp_shifter.sv
module pexp_shifter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         shift_en,
   input  logic         shift_in,
   output logic [W-1:0] q
);

   if (W < 2) begin : g_bad_width
      $error("pexp_shifter: W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q <= '0;
      else if (load)     q <= load_val;
      else if (shift_en) q <= {q[W-2:0], shift_in};
   end

endmodule

// File: rtl/pexp_addr_match.sv
module pexp_addr_match #(
   parameter int                 SEL_W   = 3,
   parameter logic [6-SEL_W:0]   ADDR_HI = 4'b0100
) (
   input  logic [6:0]       addr7,
   input  logic [SEL_W-1:0] sel,
   output logic             hit
);

   if (SEL_W < 1 || SEL_W > 6) begin : g_bad_sel
      $error("pexp_addr_match: SEL_W must be 1 to 6");
   end

   logic [6:0] own_addr;
   assign own_addr = {ADDR_HI, sel};

   // all-zero general call is never claimed, whatever the parameters
   assign hit = (addr7 == own_addr) && (addr7 != 7'd0);

endmodule

// File: rtl/pexp_i2c_target.sv
module pexp_i2c_target #(
   parameter int                 SEL_W       = 3,
   parameter logic [6-SEL_W:0]   ADDR_HI     = 4'b0100,
   parameter int                 SYNC_STAGES = 2,
   parameter logic [7:0]         RST_VAL     = 8'hFF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_i,
   input  logic             sda_i,
   output logic             sda_oe,
   input  logic [SEL_W-1:0] addr_sel,
   input  logic [7:0]       port_in,
   output logic [7:0]       port_out,
   output logic             wr_stb,
   output logic             rd_stb
);
   import pexp_pkg::*;

   localparam int CNT_W = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

   if (BYTE_W != 8) begin : g_bad_byte
      $error("pexp_i2c_target: bus byte must be 8 bits");
   end

   logic        scl_s;
   logic        sda_s;
   bus_evt_t    evt;
   pexp_state_e state;
   logic [CNT_W-1:0] cnt;
   logic        ctl_ack;
   logic        addr_hit;
   logic [7:0]  sh_q;
   logic        sh_load;
   logic        sh_en;
   logic        sh_in;

   pexp_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .scl_i (scl_i),
      .sda_i (sda_i),
      .scl_s (scl_s),
      .sda_s (sda_s),
      .evt   (evt)
   );

   pexp_addr_match #(.SEL_W(SEL_W), .ADDR_HI(ADDR_HI)) u_match (
      .addr7 (sh_q[7:1]),
      .sel   (addr_sel),
      .hit   (addr_hit)
   );

   pexp_shifter #(.W(BYTE_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (sh_load),
      .load_val (port_in),
      .shift_en (sh_en),
      .shift_in (sh_in),
      .q        (sh_q)
   );

   // shift register steering: receive on SCL rise, transmit on SCL fall
   always_comb begin
      sh_load = 1'b0;
      sh_en   = 1'b0;
      sh_in   = sda_s;
      if (!evt.start && !evt.stop) begin
         unique case (state)
            ST_ADDR, ST_WDAT: sh_en = evt.rise;
            ST_AACK:          sh_load = evt.fall && sh_q[0];
            ST_RDAT: begin
               sh_en = evt.fall && (cnt != FULL);
               sh_in = 1'b0;
            end
            ST_RACK:          sh_load = evt.fall && ctl_ack;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         cnt      <= '0;
         ctl_ack  <= 1'b0;
         sda_oe   <= 1'b0;
         port_out <= RST_VAL;
         wr_stb   <= 1'b0;
         rd_stb   <= 1'b0;
      end else begin
         wr_stb <= 1'b0;
         rd_stb <= 1'b0;
         if (evt.start) begin
            state  <= ST_ADDR;
            cnt    <= '0;
            sda_oe <= 1'b0;
         end else if (evt.stop) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
         end else begin
            unique case (state)
               ST_ADDR: begin
                  if (evt.rise) cnt <= cnt + 1'b1;
                  if (evt.fall && cnt == FULL) begin
                     if (addr_hit) begin
                        sda_oe <= 1'b1;
                        state  <= ST_AACK;
                     end else begin
                        state  <= ST_IDLE;
                     end
                  end
               end
               ST_AACK: begin
                  if (evt.fall) begin
                     cnt <= '0;
                     if (sh_q[0]) begin
                        state  <= ST_RDAT;
                        rd_stb <= 1'b1;
                        sda_oe <= ~port_in[7];
                     end else begin
                        state  <= ST_WDAT;
                        sda_oe <= 1'b0;
                     end
                  end
               end
               ST_WDAT: begin
                  if (evt.rise) cnt <= cnt + 1'b1;
                  if (evt.fall && cnt == FULL) begin
                     sda_oe <= 1'b1;
                     state  <= ST_WACK;
                  end
               end
               ST_WACK: begin
                  if (evt.fall) begin
                     sda_oe   <= 1'b0;
                     port_out <= sh_q;
                     wr_stb   <= 1'b1;
                     cnt      <= '0;
                     state    <= ST_WDAT;
                  end
               end
               ST_RDAT: begin
                  if (evt.rise) cnt <= cnt + 1'b1;
                  if (evt.fall) begin
                     if (cnt == FULL) begin
                        sda_oe <= 1'b0;
                        state  <= ST_RACK;
                     end else begin
                        sda_oe <= ~sh_q[6];
                     end
                  end
               end
               ST_RACK: begin
                  if (evt.rise) ctl_ack <= ~sda_s;
                  if (evt.fall) begin
                     if (ctl_ack) begin
                        cnt    <= '0;
                        state  <= ST_RDAT;
                        rd_stb <= 1'b1;
                        sda_oe <= ~port_in[7];
                     end else begin
                        state  <= ST_IDLE;
                     end
                  end
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

endmodule

// File: rtl/pexp_chk.sv
module pexp_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       scl_s,
   input logic       sda_oe,
   input logic [7:0] port_out,
   input logic       wr_stb,
   input logic       rd_stb
);

   // R4
   wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> !wr_stb);

   // R7
   rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stb |=> !rd_stb);

   // R6
   port_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(port_out) |-> wr_stb);

   // R2
   oe_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !scl_s);

   // R7
   stb_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_stb && rd_stb));

endmodule

bind pexp_i2c_target pexp_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .scl_s    (scl_s),
   .sda_oe   (sda_oe),
   .port_out (port_out),
   .wr_stb   (wr_stb),
   .rd_stb   (rd_stb)
);

// File: tb/pexp_i2c_target_test.sv
module pexp_i2c_target_test;

   localparam int Q = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl = 1'b1;
   logic       sda_drv = 1'b1;
   logic       sda_bus;
   logic       sda_oe;
   logic [2:0] addr_sel = 3'b101;
   logic [7:0] port_in = 8'h00;
   logic [7:0] port_out;
   logic       wr_stb;
   logic       rd_stb;

   int total = 0;
   int bad = 0;
   int wr_cnt = 0;
   int rd_cnt = 0;
   bit done = 0;

   always #2 clk = ~clk;

   assign sda_bus = sda_drv & ~sda_oe;

   pexp_i2c_target uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (scl),
      .sda_i    (sda_bus),
      .sda_oe   (sda_oe),
      .addr_sel (addr_sel),
      .port_in  (port_in),
      .port_out (port_out),
      .wr_stb   (wr_stb),
      .rd_stb   (rd_stb)
   );

   always @(posedge clk) begin
      if (wr_stb) wr_cnt <= wr_cnt + 1;
      if (rd_stb) rd_cnt <= rd_cnt + 1;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic gap(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_drv = 1'b1; gap(Q);
      scl = 1'b1;     gap(Q);
      sda_drv = 1'b0; gap(Q);
      scl = 1'b0;     gap(Q);
   endtask

   task automatic bus_stop();
      sda_drv = 1'b0; gap(Q);
      scl = 1'b1;     gap(Q);
      sda_drv = 1'b1; gap(Q);
   endtask

   task automatic send_bits(input logic [7:0] b, input int n);
      for (int i = 7; i > 7 - n; i--) begin
         sda_drv = b[i]; gap(Q);
         scl = 1'b1;     gap(2 * Q);
         scl = 1'b0;     gap(Q);
      end
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack, output logic [7:0] pre);
      send_bits(b, 8);
      sda_drv = 1'b1; gap(Q);
      scl = 1'b1;     gap(Q);
      ack = ~sda_bus;
      pre = port_out;
      gap(Q);
      scl = 1'b0;     gap(Q);
   endtask

   task automatic recv_byte(input logic give_ack, input logic [7:0] nxt, output logic [7:0] d);
      sda_drv = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         gap(Q);
         scl = 1'b1; gap(Q);
         d[i] = sda_bus;
         gap(Q);
         scl = 1'b0; gap(Q);
      end
      port_in = nxt;
      sda_drv = ~give_ack; gap(Q);
      scl = 1'b1;          gap(2 * Q);
      scl = 1'b0;          gap(Q);
      sda_drv = 1'b1;
   endtask

   task automatic t_reset();
      chk("R1 port_out", port_out, 8'hFF);
      chk("R1 sda_oe", sda_oe, 1'b0);
      chk("R1 strobes", {wr_stb, rd_stb}, 2'b00);
   endtask

   task automatic t_write_single();
      logic a; logic [7:0] p; int w0;
      w0 = wr_cnt;
      bus_start();
      send_byte(8'h4A, a, p);
      chk("R2 address ack", a, 1'b1);
      send_byte(8'hA5, a, p);
      chk("R4 data ack", a, 1'b1);
      chk("R4 old value during ack", p, 8'hFF);
      gap(Q);
      chk("R4 latch updated", port_out, 8'hA5);
      chk("R4 one wr_stb", wr_cnt - w0, 1);
      bus_stop();
   endtask

   task automatic t_write_multi();
      logic a; logic [7:0] p;
      bus_start();
      send_byte(8'h4A, a, p);
      send_byte(8'h3C, a, p);
      chk("R5 byte 1", port_out, 8'h3C);
      send_byte(8'hC3, a, p);
      chk("R5 byte 2", port_out, 8'hC3);
      send_byte(8'h0F, a, p);
      chk("R5 byte 3 ack", a, 1'b1);
      chk("R5 byte 3", port_out, 8'h0F);
      bus_stop();
   endtask

   task automatic t_wrong_addr();
      logic a; logic [7:0] p;
      bus_start();
      send_byte(8'h48, a, p);
      chk("R3 other select no ack", a, 1'b0);
      send_byte(8'h00, a, p);
      chk("R3 data after miss no ack", a, 1'b0);
      chk("R3 latch kept after miss", port_out, 8'h0F);
      bus_stop();
      bus_start();
      send_byte(8'h00, a, p);
      chk("R3 general call no ack", a, 1'b0);
      send_byte(8'h55, a, p);
      chk("R3 data after general call no ack", a, 1'b0);
      chk("R3 latch kept after general call", port_out, 8'h0F);
      bus_stop();
   endtask

   task automatic t_partial();
      logic a; logic [7:0] p; int w0;
      bus_start();
      send_byte(8'h4A, a, p);
      send_byte(8'h77, a, p);
      chk("R6 full byte", port_out, 8'h77);
      w0 = wr_cnt;
      send_bits(8'h00, 4);
      bus_stop();
      gap(Q);
      chk("R6 partial discarded", port_out, 8'h77);
      chk("R6 no strobe", wr_cnt - w0, 0);
   endtask

   task automatic t_restart();
      logic a; logic [7:0] p;
      bus_start();
      send_byte(8'h4A, a, p);
      send_bits(8'h00, 5);
      bus_start();
      chk("R10 partial dropped at restart", port_out, 8'h77);
      send_byte(8'h4A, a, p);
      chk("R10 address after restart ack", a, 1'b1);
      send_byte(8'h99, a, p);
      chk("R10 byte after restart", port_out, 8'h99);
      bus_stop();
   endtask

   task automatic t_read();
      logic a; logic [7:0] p; logic [7:0] d; int r0;
      addr_sel = 3'b010;
      gap(Q);
      bus_start();
      send_byte(8'h4A, a, p);
      chk("R2 old address ignored after pin change", a, 1'b0);
      bus_stop();
      port_in = 8'h5A;
      r0 = rd_cnt;
      bus_start();
      send_byte(8'h45, a, p);
      chk("R2 read address ack", a, 1'b1);
      recv_byte(1'b1, 8'hC6, d);
      chk("R7 first byte", d, 8'h5A);
      recv_byte(1'b0, 8'h11, d);
      chk("R8 second byte fresh sample", d, 8'hC6);
      chk("R7 read strobes", rd_cnt - r0, 2);
      chk("R9 sda released after nack", sda_oe, 1'b0);
      chk("R7 latch kept by read", port_out, 8'h99);
      send_byte(8'h45, a, p);
      chk("R9 idle after nack", a, 1'b0);
      bus_stop();
      bus_start();
      send_byte(8'h45, a, p);
      chk("R9 next start served", a, 1'b1);
      recv_byte(1'b0, 8'h11, d);
      chk("R9 read after recovery", d, 8'h11);
      bus_stop();
   endtask

   initial begin
      gap(5);
      rst_n = 1'b1;
      gap(5);
      t_reset();
      t_write_single();
      t_write_multi();
      t_wrong_addr();
      t_partial();
      t_restart();
      t_read();
      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         total++;
         bad++;
         $display("FAIL watchdog act=hung exp=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule